// File: doc/BRIEF.md
# Calendar Clock with Deferred Register Commits

This block keeps wall-clock time and calendar date. It holds seconds, minutes, hours, day of month, month and a year offset counted from 1970, which covers the years 1970 to 2033. A one-cycle `sec_tick` pulse advances the count by one second. The pulse comes from a slow-clock divider that sits outside the block. Days roll over at the length of the current month. February has 29 days when the stored leap flag is set, and the leap flag is recomputed each time the year advances.

Software reaches the block through a 32-bit word-addressed register port. Writes to the time or date register are not applied at once. The value is parked, and a busy bit is raised in the control register for that register. The new value is committed into the running counter on the second slow-clock enable after the write. The busy bit drops in the same cycle that the new value becomes readable. Writes to the control register take effect only when the key 0x16AA sits in the upper half of the written word.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the time register reads 0, the date register reads day 1, month 1, year offset 0 with leap 0 (0x00000101), and the control register reads 0.
- R2: The time register (word address 1) returns seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]. Every other bit reads as zero.
- R3: The date register (word address 2) returns day in [4:0], month (counting from 1) in [11:8], year offset in [21:16] and the leap flag in bit 22. Every other bit reads as zero.
- R4: A time write sets control bit 8 and leaves the readable time unchanged. The time is loaded on the second `slow_en` pulse after the write, and bit 8 clears on that same edge.
- R5: A date write sets control bit 7. The date commits on the second `slow_en` pulse after the write, and bit 7 clears on that same edge.
- R6: A time or date write that arrives while that register's own busy bit is set is dropped, and the first value is the one committed.
- R7: A control write updates control bit 0 (output `osc_sel`) only when bits [31:16] equal 0x16AA. Keyless writes are ignored. Bits [9:7] cannot be written, and bit 9 always reads 0.
- R8: Each `sec_tick` advances the seconds. Seconds wrap after 59 into the minutes, minutes wrap after 59 into the hours, and hours wrap after 23 into the day.
- R9: The day wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in months 1, 3, 5, 7, 8, 10 and 12. The month then advances.
- R10: February wraps after day 29 when the leap flag is set and after day 28 when it is clear. Month 12 wraps to 1 and increments the year. The leap flag becomes 1 exactly when the new year offset modulo 4 equals 2.
- R11: The year offset stops at 63. A year end at offset 63 still wraps the day and month but leaves the year at 63.
- R12: When a commit and a `sec_tick` fall in the same cycle, the committed register takes the written value without advancing. A time commit also cancels any carry into the date, while an uncommitted time still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle pulse per slow-clock period |
| sec_tick | input | 1 | One-cycle pulse per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 time, 2 date, 3 reads 0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| osc_sel | output | 1 | Key-protected control bit 0 |

## Verification
Two functions can land on the same clock edge: a deferred commit and the one-second advance. The bench provokes this by raising `slow_en` and `sec_tick` together on the commit edge. It does so once with a time write pending from 23:59:59, which must give the written time with no date carry. It does so again with a date write pending, which must give the written date while the time still steps by one second. Month lengths are swept over all twelve months with both leap settings, and the expected values are computed arithmetically.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        sec_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        osc_sel
);
  localparam logic [15:0] KEY = 16'h16AA;
  localparam logic [5:0]  YEAR_LAST = 6'd63;

  logic [5:0] sec, mnt, yr;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic       leap;
  logic [16:0] t_new;
  logic [15:0] d_new;
  logic t_busy, t_stage, d_busy, d_stage;
  logic [4:0] mlen;

  wire wr_ctrl = reg_wr && reg_addr == 2'd0 && reg_wdata[31:16] == KEY;
  wire wr_time = reg_wr && reg_addr == 2'd1 && !t_busy;
  wire wr_date = reg_wr && reg_addr == 2'd2 && !d_busy;
  wire t_commit = t_busy && t_stage && slow_en;
  wire d_commit = d_busy && d_stage && slow_en;

  wire sec_wrap = sec >= 6'd59;
  wire min_wrap = mnt >= 6'd59;
  wire hr_wrap  = hr >= 5'd23;
  wire day_carry = sec_wrap && min_wrap && hr_wrap;
  wire day_wrap = day >= mlen;
  wire mon_wrap = mon >= 4'd12;
  wire [5:0] yr_inc = yr + 6'd1;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[15:14], reg_wdata[7:6]};

  always_comb begin
    case (mon)
      4'd2:                     mlen = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: mlen = 5'd30;
      default:                  mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_busy <= 1'b0; t_stage <= 1'b0; t_new <= '0;
    end else if (wr_time) begin
      t_busy <= 1'b1; t_stage <= 1'b0;
      t_new <= {reg_wdata[20:16], reg_wdata[13:8], reg_wdata[5:0]};
    end else if (t_busy && slow_en) begin
      if (t_stage) t_busy <= 1'b0;
      t_stage <= ~t_stage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_busy <= 1'b0; d_stage <= 1'b0; d_new <= '0;
    end else if (wr_date) begin
      d_busy <= 1'b1; d_stage <= 1'b0;
      d_new <= {reg_wdata[22], reg_wdata[21:16], reg_wdata[11:8], reg_wdata[4:0]};
    end else if (d_busy && slow_en) begin
      if (d_stage) d_busy <= 1'b0;
      d_stage <= ~d_stage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) osc_sel <= 1'b0;
    else if (wr_ctrl) osc_sel <= reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; mnt <= '0; hr <= '0;
    end else if (t_commit) begin
      {hr, mnt, sec} <= t_new;
    end else if (sec_tick) begin
      sec <= sec_wrap ? 6'd0 : sec + 6'd1;
      if (sec_wrap) begin
        mnt <= min_wrap ? 6'd0 : mnt + 6'd1;
        if (min_wrap) hr <= hr_wrap ? 5'd0 : hr + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day <= 5'd1; mon <= 4'd1; yr <= '0; leap <= 1'b0;
    end else if (d_commit) begin
      {leap, yr, mon, day} <= d_new;
    end else if (sec_tick && day_carry && !t_commit) begin
      day <= day_wrap ? 5'd1 : day + 5'd1;
      if (day_wrap) begin
        mon <= mon_wrap ? 4'd1 : mon + 4'd1;
        if (mon_wrap && yr != YEAR_LAST) begin
          yr   <= yr_inc;
          leap <= yr_inc[1:0] == 2'd2;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = {22'd0, 1'b0, t_busy, d_busy, 6'd0, osc_sel};
      2'd1: reg_rdata = {11'd0, hr, 2'd0, mnt, 2'd0, sec};
      2'd2: reg_rdata = {9'd0, leap, yr, 4'd0, mon, 3'd0, day};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_en,
  input logic        sec_tick,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        osc_sel,
  input logic        t_busy,
  input logic        d_busy,
  input logic [5:0]  sec,
  input logic [5:0]  yr,
  input logic [16:0] t_new,
  input logic [16:0] t_cur
);
  assert_time_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && !t_busy) |=> t_busy);
  assert_time_commit_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t_busy) |-> $past(slow_en));
  assert_time_commit_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t_busy) |-> t_cur == $past(t_new));
  assert_date_commit_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(d_busy) |-> $past(slow_en));
  assert_time_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && t_busy) |=> $stable(t_new));
  assert_ctrl_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[31:16] != 16'h16AA) |=> $stable(osc_sel));
  assert_sec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !t_busy && sec < 6'd59) |=> sec == $past(sec) + 6'd1);
  assert_year_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (yr == 6'd63 && !d_busy) |=> yr == 6'd63);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .osc_sel(osc_sel), .t_busy(t_busy), .d_busy(d_busy), .sec(sec), .yr(yr),
  .t_new(t_new), .t_cur({hr, mnt, sec})
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_en = 1'b0, sec_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic osc_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar u_dut (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .osc_sel(osc_sel));

  function automatic [31:0] tpack(input int h, input int m, input int s);
    return (h << 16) | (m << 8) | s;
  endfunction
  function automatic [31:0] dpack(input int d, input int mo, input int y, input int l);
    return (l << 22) | (y << 16) | (mo << 8) | d;
  endfunction
  function automatic int mdays(input int mo, input int l);
    if (mo == 2) return 28 + l;
    return 30 + ((mo + mo / 8) % 2);
  endfunction

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic rd(input [1:0] a, output [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wr(input [1:0] a, input [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic pulse(input bit s, input bit t);
    @(negedge clk); slow_en = s; sec_tick = t;
    @(negedge clk); slow_en = 1'b0; sec_tick = 1'b0;
  endtask
  task automatic load(input [1:0] a, input [31:0] d);
    wr(a, d); pulse(1, 0); pulse(1, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd1, v); chk("R1 time", v, 32'h0);
    rd(2'd2, v); chk("R1 date", v, 32'h0000_0101);
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);

    // R4 commit sequence, R2 packing
    wr(2'd1, 32'hFFF7_FF3B | tpack(17, 45, 33));
    rd(2'd0, v); chk("R4 busy set", v, 32'h100);
    rd(2'd1, v); chk("R4 time unchanged", v, 32'h0);
    pulse(1, 0);
    rd(2'd1, v); chk("R4 after one slow", v, 32'h0);
    rd(2'd0, v); chk("R4 still busy", v, 32'h100);
    pulse(1, 0);
    rd(2'd1, v); chk("R2 time packed", v, tpack(23, 63, 59) & 32'h001F_3F3F);
    rd(2'd0, v); chk("R4 busy clear", v, 32'h0);
    load(2'd1, tpack(17, 45, 33));
    rd(2'd1, v); chk("R2 time fields", v, tpack(17, 45, 33));

    // R5, R3
    wr(2'd2, 32'hFF80_F000 | dpack(9, 6, 20, 1));
    rd(2'd0, v); chk("R5 busy set", v, 32'h80);
    pulse(1, 0);
    rd(2'd2, v); chk("R5 date unchanged", v, 32'h0000_0101);
    pulse(1, 0);
    rd(2'd2, v); chk("R3 date packed", v, dpack(9, 6, 20, 1));
    rd(2'd0, v); chk("R5 busy clear", v, 32'h0);

    // R6 drop while busy
    wr(2'd1, tpack(1, 2, 3));
    wr(2'd1, tpack(4, 5, 6));
    pulse(1, 0); pulse(1, 0);
    rd(2'd1, v); chk("R6 time drop", v, tpack(1, 2, 3));
    wr(2'd2, dpack(3, 3, 3, 0));
    pulse(1, 0);
    wr(2'd2, dpack(4, 4, 4, 0));
    pulse(1, 0);
    rd(2'd2, v); chk("R6 date drop", v, dpack(3, 3, 3, 0));

    // R7 key
    wr(2'd0, 32'h16AA_0381);
    chk("R7 keyed set", {31'd0, osc_sel}, 1);
    rd(2'd0, v); chk("R7 ctrl read", v, 32'h1);
    wr(2'd0, 32'h0000_0000);
    chk("R7 keyless ignored", {31'd0, osc_sel}, 1);
    wr(2'd0, 32'h16AB_0000);
    chk("R7 wrong key ignored", {31'd0, osc_sel}, 1);
    wr(2'd0, 32'h16AA_0000);
    chk("R7 keyed clear", {31'd0, osc_sel}, 0);

    // R8 sweep
    load(2'd1, tpack(0, 0, 0));
    for (int n = 1; n <= 3700; n++) begin
      pulse(0, 1);
      rd(2'd1, v);
      chk("R8 count", v, tpack(n / 3600, (n / 60) % 60, n % 60));
    end
    load(2'd1, tpack(23, 59, 58));
    load(2'd2, dpack(10, 5, 7, 0));
    pulse(0, 1);
    rd(2'd2, v); chk("R8 no carry at 58", v, dpack(10, 5, 7, 0));
    pulse(0, 1);
    rd(2'd1, v); chk("R8 hour wrap", v, 32'h0);
    rd(2'd2, v); chk("R8 day carry", v, dpack(11, 5, 7, 0));

    // R9 R10 month sweep
    for (int l = 0; l < 2; l++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int len, nm, ny, nl;
        len = mdays(mo, l);
        nm = (mo == 12) ? 1 : mo + 1;
        ny = (mo == 12) ? 6 : 5;
        nl = (mo == 12) ? ((ny % 4) == 2) : l;
        load(2'd2, dpack(len - 1, mo, 5, l));
        load(2'd1, tpack(23, 59, 59));
        pulse(0, 1);
        rd(2'd2, v); chk(mo == 2 ? "R10 feb last day" : "R9 last day", v, dpack(len, mo, 5, l));
        load(2'd1, tpack(23, 59, 59));
        pulse(0, 1);
        rd(2'd2, v); chk(mo == 2 ? "R10 feb wrap" : "R9 month wrap", v, dpack(1, nm, ny, nl));
      end
    end
    load(2'd2, dpack(31, 12, 2, 1));
    load(2'd1, tpack(23, 59, 59));
    pulse(0, 1);
    rd(2'd2, v); chk("R10 leap cleared", v, dpack(1, 1, 3, 0));

    // R11
    load(2'd2, dpack(31, 12, 63, 0));
    load(2'd1, tpack(23, 59, 59));
    pulse(0, 1);
    rd(2'd2, v); chk("R11 year hold", v, dpack(1, 1, 63, 0));

    // R12 coincidences
    load(2'd2, dpack(5, 3, 10, 0));
    load(2'd1, tpack(23, 59, 59));
    wr(2'd1, tpack(10, 0, 0));
    pulse(1, 0);
    pulse(1, 1);
    rd(2'd1, v); chk("R12 time commit wins", v, tpack(10, 0, 0));
    rd(2'd2, v); chk("R12 no date carry", v, dpack(5, 3, 10, 0));
    load(2'd1, tpack(1, 2, 3));
    wr(2'd2, dpack(7, 7, 3, 0));
    pulse(1, 0);
    pulse(1, 1);
    rd(2'd2, v); chk("R12 date commit wins", v, dpack(7, 7, 3, 0));
    rd(2'd1, v); chk("R12 time advances", v, tpack(1, 2, 4));
    load(2'd1, tpack(23, 59, 59));
    wr(2'd2, dpack(20, 8, 4, 1));
    pulse(1, 0);
    pulse(1, 1);
    rd(2'd2, v); chk("R12 date not bumped", v, dpack(20, 8, 4, 1));
    rd(2'd1, v); chk("R12 time wraps", v, 32'h0);

    rd(2'd3, v); chk("R2 unused address", v, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule